// File: doc/BRIEF.md
# Remappable Peripheral Input Crossbar

This block lets software choose which of a fixed group of general-purpose digital pins drives each remappable input of the on-chip peripherals. Every peripheral input owns a 5-bit select field. A value below the pin count picks that pin. Any larger value parks the input at a steady high level, which is the idle level of a serial receive line. Each routed signal is resynchronised through two flops before it reaches its peripheral.

The select fields sit in a small register file on a simple single-cycle write and combinational read bus. The fields are guarded by a key sequence. Two fixed words, written to the key register on consecutive bus writes, open the fields for writing. Any other write to the key register closes them again. While the fields are closed, writes to them are dropped, but reads still return the live values. Several peripherals may select the same pin, and each routing path is independent of the others.

Top module: `pin_input_xbar`

## Requirements
- R1: After reset every select field holds 31, every mapping register reads 16'h1F1F, every `periph_in` bit is 1, and the key register reads 0.
- R2: With select value n below 26, pin n appears on that peripheral input two rising edges after the pin value is sampled. A change of a select field takes effect on the output two edges after the write edge.
- R3: A select value from 26 to 31 drives the peripheral input to a constant 1, whatever the pins do. Value 25 still routes pin 25.
- R4: Peripheral p's field is in mapping register p/2 (address 0 to 3), at bits [4:0] for even p and bits [12:8] for odd p. All other bits read 0 and are not stored.
- R5: A write of 16'h4E2B to address 15, followed on the very next bus write by a write of 16'hB1D4 to address 15, sets the unlock flag. The flag reads as bit 0 at address 15.
- R6: Any other write to address 15 clears the unlock flag. Any bus write placed between the two key words stops the sequence from unlocking.
- R7: While the flag is clear, writes to addresses 0 to 3 leave every field unchanged. Reads still return the current fields.
- R8: Several peripherals may select the same pin at once, and each follows it independently.
- R9: Reads of addresses 4 to 14 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 4 | Register address (0-3 mapping, 15 key) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| rp_pins | input | 26 | Remappable pin levels |
| periph_in | output | 8 | Routed and synchronised peripheral inputs |

## Verification
The assertions assume that the pin levels and bus signals are stable around the rising edge. This lets the two-cycle relation between the routed value and the peripheral input be checked exactly. They also assume that reset is held low from time zero, so the select fields start at the park value. The bench keeps to these assumptions by changing pins and bus inputs only on the falling edge. It also starts the run in reset. Random traffic mixes both key words, lock writes and mapping writes on the same timing grid.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  typedef enum logic [0:0] {
    KEY_IDLE  = 1'b0,
    KEY_ARMED = 1'b1
  } key_state_e;

  // mapping register index that holds peripheral p
  function automatic int reg_of(int p, int fields_per_reg);
    return p / fields_per_reg;
  endfunction

  // lowest bit of peripheral p's field inside its register
  function automatic int field_lo(int p, int fields_per_reg, int stride);
    return (p % fields_per_reg) * stride;
  endfunction

  // number of registers needed for n fields
  function automatic int reg_count(int n, int fields_per_reg);
    return (n + fields_per_reg - 1) / fields_per_reg;
  endfunction

endpackage

// File: rtl/xbar_key_guard.sv
module xbar_key_guard
  import xbar_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int KEY_ADDR = 15,
  parameter logic [DATA_W-1:0] KEY_A = 16'h4E2B,
  parameter logic [DATA_W-1:0] KEY_B = 16'hB1D4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              unlocked,
  output logic              armed,
  output logic              key_wr,
  output logic              unlock_set,
  output logic              unlock_clr
);

  localparam logic [ADDR_W-1:0] KEY_SLOT = ADDR_W'(KEY_ADDR);

  key_state_e state_q, state_d;
  logic unlock_q;
  logic first_ok;

  assign key_wr     = bus_we && (bus_addr == KEY_SLOT);
  assign first_ok   = key_wr && (bus_wdata == KEY_A);
  assign unlock_set = key_wr && (bus_wdata == KEY_B) && (state_q == KEY_ARMED);
  assign unlock_clr = key_wr && !unlock_set;

  always_comb begin
    state_d = state_q;
    if (bus_we) state_d = first_ok ? KEY_ARMED : KEY_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= KEY_IDLE;
      unlock_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (unlock_set)      unlock_q <= 1'b1;
      else if (unlock_clr) unlock_q <= 1'b0;
    end
  end

  assign unlocked = unlock_q;
  assign armed    = (state_q == KEY_ARMED);

endmodule

// File: rtl/xbar_map_regs.sv
module xbar_map_regs
  import xbar_pkg::*;
#(
  parameter int NUM_PERIPH = 8,
  parameter int SEL_W = 5,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int FIELDS_PER_REG = 2,
  parameter int KEY_ADDR = 15
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              bus_we,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic [DATA_W-1:0]                 bus_wdata,
  input  logic                              unlocked,
  output logic [DATA_W-1:0]                 bus_rdata,
  output logic [NUM_PERIPH-1:0][SEL_W-1:0]  sel,
  output logic                              map_we
);

  localparam int STRIDE   = DATA_W / FIELDS_PER_REG;
  localparam int NUM_REGS = reg_count(NUM_PERIPH, FIELDS_PER_REG);

  logic map_hit;
  assign map_hit = (int'(bus_addr) < NUM_REGS);
  assign map_we  = bus_we && unlocked && map_hit;

  for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_field
    localparam int RIDX = reg_of(p, FIELDS_PER_REG);
    localparam int LO   = field_lo(p, FIELDS_PER_REG, STRIDE);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sel[p] <= '1;
      else if (map_we && (int'(bus_addr) == RIDX))
        sel[p] <= bus_wdata[LO +: SEL_W];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (int'(bus_addr) == KEY_ADDR) begin
      bus_rdata[0] = unlocked;
    end else begin
      for (int p = 0; p < NUM_PERIPH; p++) begin
        if (int'(bus_addr) == reg_of(p, FIELDS_PER_REG))
          bus_rdata[field_lo(p, FIELDS_PER_REG, STRIDE) +: SEL_W] = sel[p];
      end
    end
  end

endmodule

// File: rtl/xbar_route.sv
module xbar_route #(
  parameter int NUM_PINS = 26,
  parameter int NUM_PERIPH = 8,
  parameter int SEL_W = 5,
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic [NUM_PINS-1:0]               pins,
  input  logic [NUM_PERIPH-1:0][SEL_W-1:0]  sel,
  output logic [NUM_PERIPH-1:0]             route,
  output logic [NUM_PERIPH-1:0]             oor
);

  localparam logic [SEL_W:0] PIN_LIM = (SEL_W+1)'(NUM_PINS);

  for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_mux
    assign oor[p]   = ({1'b0, sel[p]} >= PIN_LIM);
    assign route[p] = oor[p] ? IDLE_LVL : pins[sel[p]];
  end

endmodule

// File: rtl/xbar_sync2.sv
module xbar_sync2 #(
  parameter int W = 8,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= {W{RST_VAL}};
      stab_q <= {W{RST_VAL}};
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;

endmodule

// File: rtl/pin_input_xbar.sv
module pin_input_xbar #(
  parameter int NUM_PINS = 26,
  parameter int NUM_PERIPH = 8,
  parameter int SEL_W = 5,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int FIELDS_PER_REG = 2,
  parameter int KEY_ADDR = 15,
  parameter logic [DATA_W-1:0] KEY_A = 16'h4E2B,
  parameter logic [DATA_W-1:0] KEY_B = 16'hB1D4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [NUM_PINS-1:0]   rp_pins,
  output logic [NUM_PERIPH-1:0] periph_in
);

  logic unlocked, armed, key_wr, unlock_set, unlock_clr, map_we;
  logic [NUM_PERIPH-1:0][SEL_W-1:0] sel;
  logic [NUM_PERIPH*SEL_W-1:0]      sel_flat;
  logic [NUM_PERIPH-1:0]            route, oor;

  assign sel_flat = sel;

  xbar_key_guard #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR),
    .KEY_A(KEY_A), .KEY_B(KEY_B)
  ) u_guard (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .unlocked(unlocked), .armed(armed),
    .key_wr(key_wr), .unlock_set(unlock_set), .unlock_clr(unlock_clr)
  );

  xbar_map_regs #(
    .NUM_PERIPH(NUM_PERIPH), .SEL_W(SEL_W), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .FIELDS_PER_REG(FIELDS_PER_REG), .KEY_ADDR(KEY_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .unlocked(unlocked), .bus_rdata(bus_rdata),
    .sel(sel), .map_we(map_we)
  );

  xbar_route #(
    .NUM_PINS(NUM_PINS), .NUM_PERIPH(NUM_PERIPH), .SEL_W(SEL_W),
    .IDLE_LVL(1'b1)
  ) u_route (
    .pins(rp_pins), .sel(sel), .route(route), .oor(oor)
  );

  xbar_sync2 #(.W(NUM_PERIPH), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(route), .q(periph_in)
  );

endmodule

// File: rtl/xbar_checker.sv
module xbar_checker #(
  parameter int NUM_PERIPH = 8,
  parameter int SEL_W = 5,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int NUM_REGS = 4,
  parameter int KEY_ADDR = 15,
  parameter logic [DATA_W-1:0] KEY_B = 16'hB1D4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        bus_we,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [DATA_W-1:0]           bus_wdata,
  input logic                        unlocked,
  input logic                        armed,
  input logic [NUM_PERIPH*SEL_W-1:0] sel_flat,
  input logic [NUM_PERIPH-1:0]       route,
  input logic [NUM_PERIPH-1:0]       oor,
  input logic [NUM_PERIPH-1:0]       periph_in
);

  logic key_hit, key_b_ok, map_try;
  assign key_hit  = bus_we && (int'(bus_addr) == KEY_ADDR);
  assign key_b_ok = key_hit && (bus_wdata == KEY_B) && armed;
  assign map_try  = bus_we && (int'(bus_addr) < NUM_REGS);

  // R7: locked mapping writes leave all fields as they were
  a_r7_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (map_try && !unlocked) |=> $stable(sel_flat));

  // R5: the flag only rises after the second key word on an armed sequence
  a_r5_rise_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(key_b_ok));

  // R6: any other key register write leaves the block locked
  a_r6_key_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (key_hit && !key_b_ok) |=> !unlocked);

  // R2: the peripheral sees the routed value two edges later
  a_r2_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    periph_in == $past(route, 2));

  // R3: an out-of-range select yields idle high at the output
  a_r3_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(oor, 2) & ~periph_in) == '0);

endmodule

bind pin_input_xbar xbar_checker #(
  .NUM_PERIPH(NUM_PERIPH), .SEL_W(SEL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .NUM_REGS((NUM_PERIPH + FIELDS_PER_REG - 1) / FIELDS_PER_REG),
  .KEY_ADDR(KEY_ADDR), .KEY_B(KEY_B)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .unlocked(unlocked), .armed(armed),
  .sel_flat(sel_flat), .route(route), .oor(oor), .periph_in(periph_in)
);

// File: tb/sim_pin_input_xbar.sv
`timescale 1ns/1ps
module sim_pin_input_xbar;

  localparam logic [15:0] KA = 16'h4E2B;
  localparam logic [15:0] KB = 16'hB1D4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [25:0] rp_pins = '0;
  logic [7:0] periph_in;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  pin_input_xbar u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rp_pins(rp_pins),
    .periph_in(periph_in)
  );

  // behavioural reference
  int m_sel [8];
  bit m_unl, m_arm;
  logic [7:0] m_s1, m_s2;

  function automatic logic [15:0] m_read(logic [3:0] a);
    logic [15:0] v = '0;
    if (a == 4'd15) v[0] = m_unl;
    else if (a < 4'd4) begin
      v[4:0]  = m_sel[2*a][4:0];
      v[12:8] = m_sel[2*a+1][4:0];
    end
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_sel[i]) m_sel[i] = 31;
      m_unl = 0; m_arm = 0; m_s1 = '1; m_s2 = '1;
    end else begin
      logic [7:0] mx;
      for (int p = 0; p < 8; p++) mx[p] = (m_sel[p] < 26) ? rp_pins[m_sel[p]] : 1'b1;
      m_s2 = m_s1; m_s1 = mx;
      if (bus_we) begin
        if (bus_addr == 4'd15) begin
          m_unl = (bus_wdata == KB && m_arm);
          m_arm = (bus_wdata == KA);
        end else begin
          m_arm = 0;
          if (m_unl && bus_addr < 4'd4) begin
            m_sel[2*bus_addr]   = int'(bus_wdata[4:0]);
            m_sel[2*bus_addr+1] = int'(bus_wdata[12:8]);
          end
        end
      end
    end
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // per-cycle comparison against the model
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        chk("R2 periph_in vs model", {24'd0, periph_in}, {24'd0, m_s2});
        chk("R4 rdata vs model", {16'd0, bus_rdata}, {16'd0, m_read(bus_addr)});
      end
    end
  end

  task automatic step(bit we, logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd_chk(string req, logic [3:0] a, logic [15:0] exp);
    step(0, a, '0);
    #2;
    chk(req, {16'd0, bus_rdata}, {16'd0, exp});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 4'd15, '0);
  endtask

  task automatic out_chk(string req, int p, logic exp);
    step(0, 4'd15, '0);
    #2;
    chk(req, {31'd0, periph_in[p]}, {31'd0, exp});
  endtask

  task automatic unlock();
    step(1, 4'd15, KA);
    step(1, 4'd15, KB);
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) rd_chk("R1 reset field", 4'(a), 16'h1F1F);
    rd_chk("R1 reset lock", 4'd15, 16'h0000);
    out_chk("R1 reset periph", 0, 1'b1);
    chk("R1 reset periph all", {24'd0, periph_in}, 32'h0000_00FF);
    // R7 locked write ignored
    step(1, 4'd0, 16'h0302);
    rd_chk("R7 locked write dropped", 4'd0, 16'h1F1F);
    // R5 unlock
    unlock();
    rd_chk("R5 unlocked flag", 4'd15, 16'h0001);
    // R4 field layout, extra bits not stored
    step(1, 4'd0, 16'hFF03);
    rd_chk("R4 field pack", 4'd0, 16'h1F03);
    step(1, 4'd1, 16'h0719);
    rd_chk("R4 field pack 2", 4'd1, 16'h0719);
    // R9 unmapped reads
    rd_chk("R9 unmapped 4", 4'd4, 16'h0000);
    rd_chk("R9 unmapped 14", 4'd14, 16'h0000);
    // R2 routing: periph0 on pin 3, periph2 on pin 25, periph3 on pin 7
    rp_pins = 26'h0;
    idle(3);
    chk("R2 pin3 low", {31'd0, periph_in[0]}, 32'd0);
    @(negedge clk); rp_pins[3] = 1'b1;
    @(negedge clk); #2;
    chk("R2 one edge not yet", {31'd0, periph_in[0]}, 32'd0);
    @(negedge clk); #2;
    chk("R2 two edges seen", {31'd0, periph_in[0]}, 32'd1);
    @(negedge clk); rp_pins[25] = 1'b1;
    idle(2);
    out_chk("R3 sel 25 routes pin 25", 2, 1'b1);
    // R8 same pin on peripheral 1 and 5 and 3
    step(1, 4'd0, 16'h0703);
    step(1, 4'd2, 16'h0700);
    @(negedge clk); rp_pins[7] = 1'b1;
    idle(2);
    out_chk("R8 shared pin p1", 1, 1'b1);
    chk("R8 shared pin p5", {31'd0, periph_in[5]}, 32'd1);
    chk("R8 shared pin p3", {31'd0, periph_in[3]}, 32'd1);
    @(negedge clk); rp_pins[7] = 1'b0;
    idle(2);
    out_chk("R8 shared pin p5 low", 5, 1'b0);
    chk("R8 p1 follows", {31'd0, periph_in[1]}, 32'd0);
    // R3 out of range parks at 1
    step(1, 4'd1, 16'h071A);
    rp_pins = '0;
    idle(3);
    out_chk("R3 sel 26 idle high", 2, 1'b1);
    // R6 lock command
    step(1, 4'd15, 16'h0000);
    rd_chk("R6 lock clears", 4'd15, 16'h0000);
    step(1, 4'd0, 16'h0101);
    rd_chk("R7 write after lock dropped", 4'd0, 16'h0703);
    // R6 interrupted sequence
    step(1, 4'd15, KA);
    step(1, 4'd0, 16'h0505);
    step(1, 4'd15, KB);
    rd_chk("R6 interrupted stays locked", 4'd15, 16'h0000);
    rd_chk("R6 interrupted field kept", 4'd0, 16'h0703);
    // R5 repeated first key then second key
    step(1, 4'd15, KA);
    unlock();
    rd_chk("R5 relock then unlock", 4'd15, 16'h0001);
    step(1, 4'd15, KA);
    rd_chk("R6 stray first key clears", 4'd15, 16'h0000);
    // random traffic against the model
    for (int i = 0; i < 600; i++) begin
      int r = $urandom_range(0, 9);
      logic [15:0] d = 16'($urandom);
      rp_pins = 26'($urandom);
      if (r < 2) step(1, 4'd15, KA);
      else if (r < 4) step(1, 4'd15, KB);
      else if (r == 4) step(1, 4'd15, d);
      else if (r < 8) step(1, 4'($urandom_range(0, 3)), d);
      else step(0, 4'($urandom), d);
    end
    idle(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule